// File: doc/BRIEF.md
# Single-Port RAM with Configurable Read-Output Clear

A single-port synchronous RAM whose read path ends in a data holding register (the read latch) and, optionally, a second pipeline register built from ordinary flip-flops. A clear input loads a fixed value into the last stage of that read path. Parameters decide whether the clear input exists at all, whether the clear is applied at the clock edge or asynchronously, and whether it must wait for the stage's own enable or overrides that enable.

The memory enable qualifies both writes and reads. When the output stage is present it has its own clock-enable, and the clear is aimed at that stage while the read latch keeps running. Without the output stage the clear is aimed at the read latch. A restricted mode models a memory whose read latch can be cleared only at the edge and only when enabled. In that mode, any other latch-only setting stops elaboration.

Top module: `sp_ram_rst`

## Requirements
- R1: A read (mem_en high, wr_en low) shows the addressed word on rdata after one rising edge without the output stage. With OUT_STAGE=1 and out_ce high, the word appears after two edges.
- R2: A write (mem_en and wr_en high) stores wdata at addr. With WRITE_FIRST=0 the read path receives the word stored before the write. With WRITE_FIRST=1 it receives wdata.
- R3: While mem_en is low, memory content and the read latch are unchanged.
- R4: With OUT_STAGE=1, while out_ce is low, the output stage holds its value.
- R5: With HAS_CLR=0, clr has no effect on rdata.
- R6: With OUT_STAGE=0, an applied clear loads CLR_VAL into the read latch. A one-cycle clear with mem_en held high gives CLR_VAL for exactly one cycle, and the read data then returns.
- R7: With OUT_STAGE=1, an applied clear loads CLR_VAL into the output stage only, and the read latch keeps loading. A one-cycle clear with out_ce held high gives CLR_VAL for exactly one cycle.
- R8: With CLR_OVERRIDES=0, a clear is applied only when the targeted stage's enable is high: mem_en for the latch, out_ce for the output stage. Otherwise the clear is ignored.
- R9: With CLR_OVERRIDES=1, a clear is applied whatever the state of the targeted stage's enable.
- R10: With CLR_ASYNC=1, an applied clear drives CLR_VAL onto rdata without waiting for a clock edge, and holds it until the first edge after the clear drops. With CLR_ASYNC=0, the clear acts only at a rising edge.
- R11: With LATCH_LIMITED=1 and OUT_STAGE=0, setting CLR_OVERRIDES=1 or CLR_ASYNC=1 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| mem_en | input | 1 | Memory enable for writes and read-latch loads |
| wr_en | input | 1 | Write enable, qualified by mem_en |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| clr | input | 1 | Read-output clear |
| out_ce | input | 1 | Clock-enable of the optional output stage |
| rdata | output | DW | Read data |

## Verification
The bench builds 32 instances at AW=4 and DW=8. Together they cover every combination of HAS_CLR, OUT_STAGE, CLR_ASYNC, CLR_OVERRIDES and WRITE_FIRST. Two further instances use LATCH_LIMITED=1 in its legal settings. Each instance first fills all sixteen words and then runs a long pseudo-random stream in which clears land with enables both high and low. This brings the mid-cycle effect of asynchronous clears, the enable-gated and overriding orders, and read-first against write-first into reach, all compared against an arithmetic reference every cycle.

// File: rtl/sp_ram_rst.sv
module sp_ram_rst #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter bit HAS_CLR = 1'b1,
  parameter bit OUT_STAGE = 1'b0,
  parameter bit CLR_ASYNC = 1'b0,
  parameter bit CLR_OVERRIDES = 1'b0,
  parameter bit WRITE_FIRST = 1'b0,
  parameter bit LATCH_LIMITED = 1'b0,
  parameter logic [DW-1:0] CLR_VAL = '0
) (
  input  logic          clk,
  input  logic          mem_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic          out_ce,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam bit BAD_CFG = LATCH_LIMITED && !OUT_STAGE && (CLR_OVERRIDES || CLR_ASYNC);

  // R11
  if (BAD_CFG) begin : g_bad_cfg
    $error("sp_ram_rst: restricted latch accepts only edge-timed, enable-qualified clear (R11)");
  end

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lat_q, lat_d;
  logic          lat_clr, stg_clr;

  assign lat_d   = (WRITE_FIRST && wr_en) ? wdata : mem[addr];
  assign lat_clr = HAS_CLR && !OUT_STAGE && clr && (CLR_OVERRIDES || mem_en);
  assign stg_clr = HAS_CLR &&  OUT_STAGE && clr && (CLR_OVERRIDES || out_ce);

  always_ff @(posedge clk)
    if (mem_en && wr_en) mem[addr] <= wdata;

  if (CLR_ASYNC) begin : g_lat_async
    always_ff @(posedge clk or posedge lat_clr)
      if (lat_clr)     lat_q <= CLR_VAL;
      else if (mem_en) lat_q <= lat_d;
  end else begin : g_lat_sync
    always_ff @(posedge clk)
      if (lat_clr)     lat_q <= CLR_VAL;
      else if (mem_en) lat_q <= lat_d;
  end

  if (OUT_STAGE) begin : g_stage
    logic [DW-1:0] stg_q;
    if (CLR_ASYNC) begin : g_async
      always_ff @(posedge clk or posedge stg_clr)
        if (stg_clr)     stg_q <= CLR_VAL;
        else if (out_ce) stg_q <= lat_q;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (stg_clr)     stg_q <= CLR_VAL;
        else if (out_ce) stg_q <= lat_q;
    end
    assign rdata = stg_q;
  end else begin : g_direct
    assign rdata = lat_q;
  end
endmodule

// File: rtl/sp_ram_rst_chk.sv
module sp_ram_rst_chk #(
  parameter int DW = 8,
  parameter bit HAS_CLR = 1'b1,
  parameter bit OUT_STAGE = 1'b0,
  parameter bit CLR_ASYNC = 1'b0,
  parameter bit CLR_OVERRIDES = 1'b0,
  parameter bit WRITE_FIRST = 1'b0,
  parameter logic [DW-1:0] CLR_VAL = '0
) (
  input logic          clk,
  input logic          mem_en,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic          clr,
  input logic          out_ce,
  input logic [DW-1:0] rdata
);
  logic [1:0] age = 2'd0;
  logic       armed;
  always_ff @(posedge clk)
    if (age != 2'd3) age <= age + 2'd1;
  assign armed = (age == 2'd3);

  logic live_clr, tgt_en, edge_only;
  assign live_clr  = HAS_CLR && clr;
  assign tgt_en    = OUT_STAGE ? out_ce : mem_en;
  assign edge_only = !(HAS_CLR && CLR_ASYNC);

  assert_wf_data_R2: assert property (@(posedge clk) disable iff (!armed)
    (!OUT_STAGE && WRITE_FIRST && edge_only && mem_en && wr_en && !live_clr) |=> rdata == $past(wdata));

  assert_hold_en_R3: assert property (@(posedge clk) disable iff (!armed)
    (!OUT_STAGE && edge_only && !mem_en && !(live_clr && CLR_OVERRIDES)) |=> $stable(rdata));

  assert_hold_ce_R4: assert property (@(posedge clk) disable iff (!armed)
    (OUT_STAGE && edge_only && !out_ce && !(live_clr && CLR_OVERRIDES)) |=> $stable(rdata));

  assert_latch_clr_R6: assert property (@(posedge clk) disable iff (!armed)
    (!OUT_STAGE && edge_only && live_clr && mem_en) |=> rdata == CLR_VAL);

  assert_stage_clr_R7: assert property (@(posedge clk) disable iff (!armed)
    (OUT_STAGE && edge_only && live_clr && out_ce) |=> rdata == CLR_VAL);

  assert_override_R9: assert property (@(posedge clk) disable iff (!armed)
    (CLR_OVERRIDES && edge_only && live_clr && !tgt_en) |=> rdata == CLR_VAL);

  assert_async_now_R10: assert property (@(posedge clk) disable iff (!armed)
    (!edge_only && live_clr && (CLR_OVERRIDES || tgt_en)) |-> rdata == CLR_VAL);
endmodule

bind sp_ram_rst sp_ram_rst_chk #(
  .DW(DW), .HAS_CLR(HAS_CLR), .OUT_STAGE(OUT_STAGE), .CLR_ASYNC(CLR_ASYNC),
  .CLR_OVERRIDES(CLR_OVERRIDES), .WRITE_FIRST(WRITE_FIRST), .CLR_VAL(CLR_VAL)
) u_chk (
  .clk(clk), .mem_en(mem_en), .wr_en(wr_en), .wdata(wdata),
  .clr(clr), .out_ce(out_ce), .rdata(rdata)
);

// File: tb/test_sp_ram_rst.sv
module run_cfg #(
  parameter bit HAS_CLR = 1'b1,
  parameter bit OUT_STAGE = 1'b0,
  parameter bit CLR_ASYNC = 1'b0,
  parameter bit CLR_OVERRIDES = 1'b0,
  parameter bit WRITE_FIRST = 1'b0,
  parameter bit LATCH_LIMITED = 1'b0,
  parameter int SEED = 1
) (
  input  logic clk,
  output int   checks,
  output int   fails,
  output logic done
);
  localparam logic [7:0] CV = 8'hA5;
  logic       mem_en = 0, wr_en = 0, clr = 0, out_ce = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;

  sp_ram_rst #(.AW(4), .DW(8), .HAS_CLR(HAS_CLR), .OUT_STAGE(OUT_STAGE),
    .CLR_ASYNC(CLR_ASYNC), .CLR_OVERRIDES(CLR_OVERRIDES), .WRITE_FIRST(WRITE_FIRST),
    .LATCH_LIMITED(LATCH_LIMITED), .CLR_VAL(CV)) i_sp_ram_rst (
    .clk(clk), .mem_en(mem_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .clr(clr), .out_ce(out_ce), .rdata(rdata));

  logic [7:0] m_mem [16];
  logic [7:0] m_lat, m_stg;
  string      tag = "R1";

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  always @(posedge clk) begin
    logic [7:0] ld, old_lat;
    logic gl, gs, ten;
    ld      = (WRITE_FIRST && wr_en) ? wdata : m_mem[addr];
    ten     = OUT_STAGE ? out_ce : mem_en;
    gl      = HAS_CLR && !OUT_STAGE && clr && (CLR_OVERRIDES || mem_en);
    gs      = HAS_CLR &&  OUT_STAGE && clr && (CLR_OVERRIDES || out_ce);
    old_lat = m_lat;
    if (gl) m_lat = CV; else if (mem_en) m_lat = ld;
    if (gs) m_stg = CV; else if (out_ce) m_stg = old_lat;
    if (mem_en && wr_en) m_mem[addr] = wdata;
    if (clr && !HAS_CLR)   tag = "R5";
    else if (gl || gs)     tag = !ten ? "R9" : (OUT_STAGE ? "R7" : "R6");
    else if (clr)          tag = "R8";
    else if (OUT_STAGE && !out_ce) tag = "R4";
    else if (!mem_en)      tag = "R3";
    else if (wr_en)        tag = "R2";
    else                   tag = "R1";
  end

  task automatic step(input logic e, input logic w, input logic [3:0] a,
                      input logic [7:0] d, input logic c, input logic oc, input bit chk);
    logic [7:0] exp;
    @(posedge clk);
    #1;
    mem_en = e; wr_en = w; addr = a; wdata = d; clr = c; out_ce = oc;
    #2;
    if (CLR_ASYNC && HAS_CLR && c && (CLR_OVERRIDES || (OUT_STAGE ? oc : e))) begin
      if (OUT_STAGE) m_stg = CV; else m_lat = CV;
      tag = "R10";
    end
    exp = OUT_STAGE ? m_stg : m_lat;
    if (chk) begin
      checks++;
      if (rdata !== exp) begin
        fails++;
        $display("FAIL %s cfg seed=%0d: rdata=%h expected=%h", tag, SEED, rdata, exp);
      end
    end
  endtask

  initial begin
    logic [31:0] rs;
    checks = 0; fails = 0; done = 0;
    rs = SEED;
    for (int i = 0; i < 16; i++) step(1, 1, i[3:0], 8'(i * 37 + 11), 0, 1, 0);
    for (int i = 0; i < 4; i++)  step(1, 0, i[3:0], 8'h00, 0, 1, 0);
    // directed: one-cycle clear with enables high (R6, R7), then clear with enables low (R8, R9)
    step(1, 0, 4'd3, 8'h00, 0, 1, 1);
    step(1, 0, 4'd4, 8'h00, 1, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 4'd5, 8'h00, 0, 1, 1);
    step(0, 0, 4'd6, 8'h00, 1, 0, 1);
    step(0, 0, 4'd6, 8'h00, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 4'd7, 8'h00, 0, 1, 1);
    for (int i = 0; i < 300; i++) begin
      rs = nxt(rs);
      step(rs[1:0] != 0, rs[3:2] == 0, rs[7:4], rs[15:8], rs[18:16] == 0, rs[21:20] != 0, 1);
    end
    done = 1;
  end
endmodule

module test_sp_ram_rst;
  logic clk = 0;
  always #5 clk = ~clk;

  int   chk [34];
  int   fl  [34];
  logic dn  [34];

  for (genvar g = 0; g < 32; g++) begin : g_cfg
    run_cfg #(.HAS_CLR((g & 1) != 0), .OUT_STAGE((g & 2) != 0), .CLR_ASYNC((g & 4) != 0),
      .CLR_OVERRIDES((g & 8) != 0), .WRITE_FIRST((g & 16) != 0), .LATCH_LIMITED(1'b0),
      .SEED(g * 7919 + 13)) u_run (.clk(clk), .checks(chk[g]), .fails(fl[g]), .done(dn[g]));
  end
  // R11: restricted mode in its legal settings only
  run_cfg #(.HAS_CLR(1'b1), .OUT_STAGE(1'b0), .CLR_ASYNC(1'b0), .CLR_OVERRIDES(1'b0),
    .WRITE_FIRST(1'b0), .LATCH_LIMITED(1'b1), .SEED(424242))
    u_lim0 (.clk(clk), .checks(chk[32]), .fails(fl[32]), .done(dn[32]));
  run_cfg #(.HAS_CLR(1'b1), .OUT_STAGE(1'b1), .CLR_ASYNC(1'b1), .CLR_OVERRIDES(1'b1),
    .WRITE_FIRST(1'b1), .LATCH_LIMITED(1'b1), .SEED(98765))
    u_lim1 (.clk(clk), .checks(chk[33]), .fails(fl[33]), .done(dn[33]));

  initial begin
    int  total, bad, cyc;
    bit  all;
    cyc = 0; all = 0;
    while (!all && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      all = 1;
      for (int k = 0; k < 34; k++) if (dn[k] !== 1'b1) all = 0;
    end
    total = 0; bad = 0;
    for (int k = 0; k < 34; k++) begin
      total += chk[k];
      bad   += fl[k];
    end
    if (!all) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=unfinished expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", total, bad);
    $finish;
  end
endmodule